// File: doc/BRIEF.md
# Watchdog Timer With Guarded Disable

This block is a watchdog that counts cycles of its own clock. Once enabled, it raises a single-cycle system reset request whenever software fails to kick it within a timeout. The timeout is chosen by a 3-bit prescale code. Software controls the watchdog through one 8-bit control register. That register holds a prescale field, an enable bit and a guard bit. A kick input restarts the count.

Switching the watchdog on is a single write. Switching it off takes a timed sequence, so a stray write cannot silence it. First, one write sets the guard bit and the enable bit together. This opens a window of GUARD_CYCLES clock edges, and the guard bit reads back as one while the window is open. A write that clears the enable bit succeeds only while the window is open. The guard bit then clears itself.

The base timeout is 2^BASE_LOG2 cycles, which is 16384 by default. Every step of the prescale code doubles it. Oscillator generation, clock-domain crossing and power-on reset are handled outside the block.

Top module: `wdg_core`

## Requirements
- R1: Bits 7:5 of the control register always read as zero. After reset the whole register reads 0x00 and the reset request is low.
- R2: With prescale code n (bits 2:0), the timeout is 2^(BASE_LOG2+n) clock cycles. The first request rises that many edges after the edge that enabled the watchdog or applied a kick.
- R3: A write with bit 4 (guard) and bit 3 (enable) both one sets the guard bit. The guard bit reads one for exactly GUARD_CYCLES edges, then clears itself. A repeated arming write reloads the window.
- R4: A write with bit 3 zero clears the enable bit when the guard bit reads one at that edge. This includes the last edge of the window.
- R5: A write with bit 3 zero while the guard bit reads zero leaves the enable bit at one.
- R6: A write with bit 3 one enables the watchdog at any time, with no sequence. Counting starts from zero.
- R7: On timeout the reset request is high for exactly one cycle. Counting restarts from zero, so requests repeat once per timeout.
- R8: A kick sampled at an edge clears the count and suppresses any request at that edge.
- R9: While the enable bit reads zero, the count is held at zero and no request is raised.
- R10: A prescale change applies from the next edge on. If the count already equals or exceeds the new timeout minus one, the request fires at that next edge.
- R11: Every write updates the prescale field, including a write whose attempt to clear the enable bit is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Write data: [4] guard, [3] enable, [2:0] prescale |
| rd_data | output | 8 | Control register read value |
| kick | input | 1 | Restart the timeout count |
| rst_req | output | 1 | One-cycle system reset request |

## Verification
The bound checker watches the following on every cycle:
- the reserved bits stay zero;
- the guard bit rises only after an arming write and drops after its window length;
- the enable bit falls only while the guard is open;
- a write always lands in the prescale field;
- a request never lasts more than one cycle and never follows a kick or a disabled cycle.

Only the bench scenarios can show that the timeout lengths match the prescale codes. They also show the boundary between the last open window edge and the first closed one, the restart after each request, and the immediate firing when the timeout shrinks below the running count.

// File: rtl/wdg_pkg.sv
// Shared field layout for the watchdog control register.
// Assumes an 8-bit register with three reserved high bits.
package wdg_pkg;
    localparam int REG_W   = 8;
    localparam int PS_W    = 3;
    localparam int BIT_GRD = 4;
    localparam int BIT_EN  = 3;

    typedef struct packed {
        logic            grd;
        logic            en;
        logic [PS_W-1:0] ps;
    } wdg_ctrl_t;

    // Assemble the read value with reserved bits forced to zero.
    function automatic logic [REG_W-1:0] pack_ctrl(input wdg_ctrl_t c);
        logic [REG_W-1:0] v;
        v = '0;
        v[BIT_GRD]    = c.grd;
        v[BIT_EN]     = c.en;
        v[PS_W-1:0]   = c.ps;
        return v;
    endfunction
endpackage

// File: rtl/wdg_guard_win.sv
// Self-expiring disable window.
// An arm pulse (re)loads GUARD_CYCLES; the window reads open while the
// remaining count is non-zero, and closes after that many edges.
module wdg_guard_win #(
    parameter int GUARD_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic open
);
    localparam int GW = $clog2(GUARD_CYCLES + 1);

    logic [GW-1:0] left_q;

    // Load on arm, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            left_q <= '0;
        else if (arm)
            left_q <= GW'(GUARD_CYCLES);
        else if (left_q != '0)
            left_q <= left_q - GW'(1);
    end

    assign open = (left_q != '0);
endmodule

// File: rtl/wdg_ctrl_reg.sv
// Enable and prescale storage with the guarded clear rule.
// Assumes win_open is the current guard state sampled at the same edge.
module wdg_ctrl_reg
    import wdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [4:0]       wr_bits,
    input  logic             win_open,
    output logic             arm,
    output logic             en,
    output logic [PS_W-1:0]  ps
);
    logic set_en;
    logic clr_req;

    // Decode the write into arm, set and clear requests.
    always_comb begin
        set_en  = wr_en && wr_bits[BIT_EN];
        clr_req = wr_en && !wr_bits[BIT_EN];
        arm     = set_en && wr_bits[BIT_GRD];
    end

    // Enable bit: set freely, cleared only inside the guard window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            en <= 1'b0;
        else if (set_en)
            en <= 1'b1;
        else if (clr_req && win_open)
            en <= 1'b0;
    end

    // Prescale field follows every write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ps <= '0;
        else if (wr_en)
            ps <= wr_bits[PS_W-1:0];
    end
endmodule

// File: rtl/wdg_timeout.sv
// Prescaled timeout counter with a registered one-cycle fire pulse.
// Timeout is 2^(BASE_LOG2+ps) cycles; kick and disable clear the count.
module wdg_timeout
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2 = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [PS_W-1:0] ps,
    input  logic            kick,
    output logic            fire
);
    localparam int CW = BASE_LOG2 + (1 << PS_W);
    localparam logic [CW-1:0] ONE = CW'(1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] term;
    logic          reached;

    // Terminal count for the current prescale code.
    always_comb begin
        term    = (ONE << (BASE_LOG2 + int'(ps))) - ONE;
        reached = (cnt_q >= term);
    end

    // Count, wrap on timeout and emit the pulse; kick has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            fire  <= 1'b0;
        end else begin
            fire <= 1'b0;
            if (!en || kick)
                cnt_q <= '0;
            else if (reached) begin
                cnt_q <= '0;
                fire  <= 1'b1;
            end else
                cnt_q <= cnt_q + ONE;
        end
    end
endmodule

// File: rtl/wdg_core.sv
// Watchdog top: control register, guard window and timeout counter.
// Assumes all inputs are synchronous to clk.
module wdg_core
    import wdg_pkg::*;
#(
    parameter int BASE_LOG2    = 14,
    parameter int GUARD_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             kick,
    output logic             rst_req
);
    wdg_ctrl_t ctrl;
    logic      arm;
    logic      win_open;
    logic      en;
    logic [PS_W-1:0] ps;
    logic      unused_rsv;

    assign unused_rsv = ^wr_data[REG_W-1:BIT_GRD+1];

    wdg_guard_win #(.GUARD_CYCLES(GUARD_CYCLES)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (arm),
        .open (win_open)
    );

    wdg_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_bits (wr_data[BIT_GRD:0]),
        .win_open(win_open),
        .arm     (arm),
        .en      (en),
        .ps      (ps)
    );

    wdg_timeout #(.BASE_LOG2(BASE_LOG2)) u_tmo (
        .clk  (clk),
        .rst_n(rst_n),
        .en   (en),
        .ps   (ps),
        .kick (kick),
        .fire (rst_req)
    );

    // Gather register fields for read-back.
    always_comb begin
        ctrl.grd = win_open;
        ctrl.en  = en;
        ctrl.ps  = ps;
        rd_data  = pack_ctrl(ctrl);
    end
endmodule

// File: rtl/wdg_core_chk.sv
// Port-level protocol checker for wdg_core, attached by bind.
module wdg_core_chk #(
    parameter int GUARD_CYCLES = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic [7:0] rd_data,
    input logic       kick,
    input logic       rst_req
);
    localparam int HW = $clog2(GUARD_CYCLES + 2) + 1;

    logic          arm_w;
    logic [HW-1:0] hold_cnt;

    assign arm_w = wr_en && wr_data[4] && wr_data[3];

    // Track how long the guard bit has been open since the last arm.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hold_cnt <= '0;
        else if (arm_w)
            hold_cnt <= HW'(1);
        else if (rd_data[4])
            hold_cnt <= hold_cnt + HW'(1);
        else
            hold_cnt <= '0;
    end

    // R1
    rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[7:5] == 3'b000);

    // R3
    grd_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[4]) |-> $past(arm_w));

    // R3
    grd_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[4] |-> (hold_cnt >= HW'(1) && hold_cnt <= HW'(GUARD_CYCLES)));

    // R3
    grd_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_cnt == HW'(GUARD_CYCLES) && !arm_w) |=> !rd_data[4]);

    // R5
    en_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[3]) |-> ($past(rd_data[4]) && $past(wr_en && !wr_data[3])));

    // R6
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[3]) |=> rd_data[3]);

    // R11
    ps_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rd_data[2:0] == $past(wr_data[2:0]));

    // R7
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8
    kick_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> !rst_req);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_data[3] |=> !rst_req);
endmodule

bind wdg_core wdg_core_chk #(.GUARD_CYCLES(GUARD_CYCLES)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .rd_data(rd_data),
    .kick   (kick),
    .rst_req(rst_req)
);

// File: tb/wdg_core_test.sv
// Scoreboard bench: the driver queues timed expectations, the monitor
// compares them at the falling edge of the cycle they are due.
module wdg_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       kick = 1'b0;
    logic [7:0] rd_data;
    logic       rst_req;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int         at;
        string      req;
        bit         is_rst;
        logic [7:0] val;
    } exp_t;

    exp_t       q[$];
    exp_t       cur;
    logic [7:0] act;

    wdg_core #(.BASE_LOG2(4), .GUARD_CYCLES(4)) uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .kick   (kick),
        .rst_req(rst_req)
    );

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Insert an expectation in time order.
    task automatic push(input int at, input string req, input bit is_rst, input logic [7:0] val);
        exp_t e;
        int   idx;
        e.at = at; e.req = req; e.is_rst = is_rst; e.val = val;
        idx = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].at > at) begin
                idx = i;
                break;
            end
        end
        q.insert(idx, e);
    endtask

    // Monitor: pop every due item and compare.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= cyc) begin
            cur = q.pop_front();
            total++;
            act = cur.is_rst ? {7'b0, rst_req} : rd_data;
            if (cur.at != cyc || act !== cur.val) begin
                bad++;
                $display("FAIL %s: cycle %0d %s actual=%h expected=%h",
                         cur.req, cyc, cur.is_rst ? "rst_req" : "rd_data", act, cur.val);
            end
        end
    end

    task automatic wr(input logic [7:0] d, input bit k);
        wr_en = 1'b1; wr_data = d; kick = k;
        @(negedge clk);
        wr_en = 1'b0; kick = 1'b0;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        int c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c = cyc;
        // R1 reset state
        push(c + 1, "R1", 0, 8'h00);
        push(c + 1, "R1", 1, 8'h00);
        wait_until(c + 2);

        // R6 enable, R2 code 0 timeout of 16, R7 repeat
        c = cyc;
        push(c + 1,  "R6", 0, 8'h08);
        push(c + 16, "R2", 1, 8'h00);
        push(c + 17, "R2", 1, 8'h01);
        push(c + 18, "R7", 1, 8'h00);
        push(c + 33, "R7", 1, 8'h01);
        wr(8'h08, 1'b0);

        // R8 kick ten cycles after the last request
        wait_until(c + 43);
        c = cyc;
        push(c + 6,  "R8", 1, 8'h00);
        push(c + 16, "R8", 1, 8'h00);
        push(c + 17, "R8", 1, 8'h01);
        kick = 1'b1;
        @(negedge clk);
        kick = 1'b0;
        wait_until(c + 18);

        // R5 unguarded clear refused, R11 prescale still written
        c = cyc;
        push(c + 1, "R5", 0, 8'h08);
        wr(8'h00, 1'b0);
        c = cyc;
        push(c + 1, "R11", 0, 8'h0A);
        wr(8'h02, 1'b0);

        // R3 arm, R4 clear in window, R9 quiet while disabled
        c = cyc;
        push(c + 1,   "R3", 0, 8'h1A);
        push(c + 4,   "R4", 0, 8'h12);
        push(c + 5,   "R3", 0, 8'h02);
        push(c + 100, "R9", 1, 8'h00);
        wr(8'h1A, 1'b0);
        wait_until(c + 3);
        wr(8'h02, 1'b0);
        wait_until(c + 101);

        // R4 clear on last open edge
        c = cyc;
        push(c + 1, "R3", 0, 8'h18);
        push(c + 4, "R3", 0, 8'h18);
        push(c + 5, "R4", 0, 8'h00);
        wr(8'h18, 1'b0);
        wait_until(c + 4);
        wr(8'h00, 1'b0);
        wait_until(c + 6);

        // R3 window closed one edge later, R5 clear refused
        c = cyc;
        push(c + 1, "R3", 0, 8'h18);
        push(c + 5, "R3", 0, 8'h08);
        push(c + 6, "R5", 0, 8'h08);
        wr(8'h18, 1'b0);
        wait_until(c + 5);
        wr(8'h00, 1'b0);
        wait_until(c + 7);

        // R10 shrink the timeout below the running count
        c = cyc;
        push(c + 1,  "R11", 0, 8'h0B);
        push(c + 20, "R2",  1, 8'h00);
        push(c + 42, "R10", 1, 8'h00);
        push(c + 43, "R10", 1, 8'h01);
        push(c + 59, "R2",  1, 8'h01);
        wr(8'h0B, 1'b1);
        wait_until(c + 41);
        push(c + 42, "R11", 0, 8'h08);
        wr(8'h08, 1'b0);
        wait_until(c + 60);

        // R2 code 1 gives 32 cycles, R7 one-cycle pulse
        c = cyc;
        push(c + 32, "R2", 1, 8'h00);
        push(c + 33, "R2", 1, 8'h01);
        push(c + 34, "R7", 1, 8'h00);
        wr(8'h09, 1'b1);
        wait_until(c + 35);

        // R2 code 7 gives 2048 cycles
        c = cyc;
        push(c + 2048, "R2", 1, 8'h00);
        push(c + 2049, "R2", 1, 8'h01);
        wr(8'h0F, 1'b1);
        wait_until(c + 2051);

        if (q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: %0d items never compared", q.size());
        end
        finish_run();
    end
endmodule